// File: doc/BRIEF.md
# Big-number operation control registers

This block is the host-facing control bank of a multi-word arithmetic engine. Software programs the RAM word addresses of up to four operand and result vectors, the word counts of two source vectors, a shift amount and a function word that selects the operation. Setting the run bit starts the operation. The block then hands a frozen copy of the operand settings to the arithmetic datapath, raises a one-cycle start strobe and waits for the datapath's done strobe.

The pointer and length registers are double-buffered. Host writes always land in a pending copy, which is visible on the read port. The copy that drives the datapath is refreshed only when an operation is launched, so the next job can be prepared while the current one runs. The shift amount and the operation-select bits are locked while the run bit is set.

A stall-result flag lets software hold a finished operation: completion is not published and the run bit stays set until the flag is cleared again. After reset the run bit reads as one for a short start-up window, then drops without any operation taking place.

Top module: `bignum_ctl_regs`

## Requirements
- R1: While reset is asserted and directly after it is released, indices 0 to 6 read as zero and index 7 (function) reads 0x00008000.
- R2: Indices 0 to 3 hold the pointers of vectors A, B, C and D as 11-bit word addresses in bits 10:0. Bits 31:11 ignore writes and read as zero.
- R3: Indices 4 and 5 hold the lengths of vectors A and B as 9-bit word counts in bits 8:0. Bits 31:9 ignore writes and read as zero.
- R4: Pointer and length writes are accepted at any time into a pending copy that is returned on the read port. The `act_ptr` and `act_len` outputs (vector A in the lowest slice) change only on the clock edge that starts an operation, and then take the pending values held before that edge.
- R5: Index 6 holds a 5-bit shift amount in bits 4:0 (upper bits read zero). A write to it is ignored while the run bit is 1. `act_shift` always equals the stored value.
- R6: Index 7 reads {7'b0, stall bit 24, 8'b0, run bit 15, sequencer code 14:12, operation bits 11:0}. Bit 2 is reserved and reads zero. Bits 14:12 and 11:0 (also shown on `act_seq`/`act_ops`) ignore writes while run is 1. A write with bit 15 set while run is 0 sets run and pulses `op_start` for the one cycle after that edge.
- R7: While an operation runs with the stall bit 0, a sampled `op_done` clears run and pulses `publish` for one cycle, both on the same edge.
- R8: If the stall bit is 1 when `op_done` is sampled, run stays 1 and no `publish` is issued. On the edge after the edge that writes the stall bit back to 0, run clears and `publish` pulses. The stall bit is writable at all times.
- R9: After reset the run bit stays 1 for BOOT_CYCLES clock edges and then clears with no `publish` and no `op_start`. Function and shift writes during that window are ignored.
- R10: `op_done` received while no operation is running has no effect: no `publish`, and the registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 32 | Read data (combinational from rd_idx) |
| op_done | input | 1 | Completion strobe from the datapath |
| op_start | output | 1 | One-cycle launch strobe to the datapath |
| publish | output | 1 | One-cycle strobe: results may be published |
| act_ptr | output | 44 | Frozen pointers D,C,B,A (A in bits 10:0) |
| act_len | output | 18 | Frozen lengths B,A (A in bits 8:0) |
| act_shift | output | 5 | Shift amount |
| act_ops | output | 12 | Operation-select bits |
| act_seq | output | 3 | Sequencer operation code |

## Verification
The main function is exercised with several patterns: writes with all-ones upper bits, which separate field width from reserved masking; pending writes made during a running job, which show whether the pending copy and the frozen copy are kept apart; locked writes issued during the start-up window and during a job; and a stalled completion released several cycles later, which pins down the exact edge of publication. A stray done strobe while idle shows that completion is gated by the run state. A behavioural model is compared against every output on every clock, and the read index is swept so that each register is compared.

// File: rtl/bnc_pkg.sv
package bnc_pkg;
    localparam int NUM_PTR  = 4;
    localparam int NUM_LEN  = 2;
    localparam int IDX_W    = 3;
    localparam int OPS_W    = 12;
    localparam int SEQ_W    = 3;

    localparam logic [IDX_W-1:0] IDX_LEN0  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_SHIFT = 3'd6;
    localparam logic [IDX_W-1:0] IDX_FUNC  = 3'd7;

    localparam int BIT_SEQ_LO = 12;
    localparam int BIT_RUN    = 15;
    localparam int BIT_STALL  = 24;

    localparam logic [OPS_W-1:0] OPS_MASK = 12'hFFB;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_IDLE,
        ST_BUSY,
        ST_HELD
    } run_state_e;
endpackage

// File: rtl/bnc_operand_bank.sv
module bnc_operand_bank #(
    parameter int N = 4,
    parameter int W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   wr_sel,
    input  logic [W-1:0]   wr_val,
    input  logic           load,
    output logic [N*W-1:0] pend,
    output logic [N*W-1:0] live
);
    typedef struct packed {
        logic [N*W-1:0] pend;
        logic [N*W-1:0] live;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < N; i++) begin
            if (wr_sel[i]) begin
                d.pend[i*W +: W] = wr_val;
            end
        end
        if (load) begin
            d.live = q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pend = q.pend;
    assign live = q.live;
endmodule

// File: rtl/bnc_run_ctl.sv
module bnc_run_ctl
    import bnc_pkg::*;
#(
    parameter int BOOT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fn_wr,
    input  logic fn_run_bit,
    input  logic fn_stall_bit,
    input  logic op_done,
    output logic run,
    output logic stall,
    output logic op_start,
    output logic publish,
    output logic load
);
    localparam int CNT_W = $clog2(BOOT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BOOT_CYCLES - 1);

    typedef struct packed {
        run_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             stall;
        logic             start;
        logic             pub;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.pub   = 1'b0;
        load    = fn_wr && fn_run_bit && (q.state == ST_IDLE);
        unique case (q.state)
            ST_BOOT: begin
                if (q.cnt == CNT_LAST) begin
                    d.state = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (load) begin
                    d.state = ST_BUSY;
                    d.start = 1'b1;
                end
            end
            ST_BUSY: begin
                if (op_done) begin
                    if (q.stall) begin
                        d.state = ST_HELD;
                    end else begin
                        d.state = ST_IDLE;
                        d.pub   = 1'b1;
                    end
                end
            end
            ST_HELD: begin
                if (!q.stall) begin
                    d.state = ST_IDLE;
                    d.pub   = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (fn_wr) begin
            d.stall = fn_stall_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_BOOT;
            q.cnt   <= '0;
            q.stall <= 1'b0;
            q.start <= 1'b0;
            q.pub   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign run      = (q.state != ST_IDLE);
    assign stall    = q.stall;
    assign op_start = q.start;
    assign publish  = q.pub;
endmodule

// File: rtl/bignum_ctl_regs.sv
module bignum_ctl_regs
    import bnc_pkg::*;
#(
    parameter int PTR_W       = 11,
    parameter int LEN_W       = 9,
    parameter int SHIFT_W     = 5,
    parameter int BOOT_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [31:0]              wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [31:0]              rd_data,
    input  logic                     op_done,
    output logic                     op_start,
    output logic                     publish,
    output logic [NUM_PTR*PTR_W-1:0] act_ptr,
    output logic [NUM_LEN*LEN_W-1:0] act_len,
    output logic [SHIFT_W-1:0]       act_shift,
    output logic [OPS_W-1:0]         act_ops,
    output logic [SEQ_W-1:0]         act_seq
);
    logic run_w, stall_w, load_w;
    logic fn_wr;
    logic [NUM_PTR-1:0] ptr_sel;
    logic [NUM_LEN-1:0] len_sel;
    logic [NUM_PTR*PTR_W-1:0] ptr_pend;
    logic [NUM_LEN*LEN_W-1:0] len_pend;
    logic [PTR_W-1:0] ptr_view [NUM_PTR];
    logic [LEN_W-1:0] len_view [NUM_LEN];

    assign fn_wr = wr_en && (wr_idx == IDX_FUNC);

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        assign ptr_sel[i]  = wr_en && (wr_idx == IDX_W'(i));
        assign ptr_view[i] = ptr_pend[i*PTR_W +: PTR_W];
    end
    for (genvar j = 0; j < NUM_LEN; j++) begin : g_len
        assign len_sel[j]  = wr_en && (wr_idx == IDX_LEN0 + IDX_W'(j));
        assign len_view[j] = len_pend[j*LEN_W +: LEN_W];
    end

    bnc_operand_bank #(.N(NUM_PTR), .W(PTR_W)) u_ptr_bank (
        .clk(clk), .rst_n(rst_n), .wr_sel(ptr_sel),
        .wr_val(wr_data[PTR_W-1:0]), .load(load_w),
        .pend(ptr_pend), .live(act_ptr)
    );

    bnc_operand_bank #(.N(NUM_LEN), .W(LEN_W)) u_len_bank (
        .clk(clk), .rst_n(rst_n), .wr_sel(len_sel),
        .wr_val(wr_data[LEN_W-1:0]), .load(load_w),
        .pend(len_pend), .live(act_len)
    );

    bnc_run_ctl #(.BOOT_CYCLES(BOOT_CYCLES)) u_run (
        .clk(clk), .rst_n(rst_n), .fn_wr(fn_wr),
        .fn_run_bit(wr_data[BIT_RUN]), .fn_stall_bit(wr_data[BIT_STALL]),
        .op_done(op_done), .run(run_w), .stall(stall_w),
        .op_start(op_start), .publish(publish), .load(load_w)
    );

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [OPS_W-1:0]   ops;
        logic [SEQ_W-1:0]   seq;
    } fn_t;

    fn_t q, d;

    always_comb begin
        d = q;
        if (wr_en && !run_w) begin
            if (wr_idx == IDX_SHIFT) begin
                d.shift = wr_data[SHIFT_W-1:0];
            end
            if (wr_idx == IDX_FUNC) begin
                d.ops = wr_data[OPS_W-1:0] & OPS_MASK;
                d.seq = wr_data[BIT_SEQ_LO +: SEQ_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign act_shift = q.shift;
    assign act_ops   = q.ops;
    assign act_seq   = q.seq;

    always_comb begin
        rd_data = '0;
        if (rd_idx < IDX_LEN0) begin
            rd_data = 32'(ptr_view[rd_idx[1:0]]);
        end else if (rd_idx == IDX_SHIFT) begin
            rd_data = 32'(q.shift);
        end else if (rd_idx == IDX_FUNC) begin
            rd_data = {7'b0, stall_w, 8'b0, run_w, q.seq, q.ops};
        end else begin
            rd_data = 32'(len_view[rd_idx[0]]);
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{wr_data[31:25], wr_data[23:16]};
endmodule

// File: rtl/bignum_ctl_regs_chk.sv
module bignum_ctl_regs_chk #(
    parameter int PTR_W   = 11,
    parameter int SHIFT_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run,
    input logic                 stall,
    input logic                 load,
    input logic                 op_done,
    input logic                 op_start,
    input logic                 publish,
    input logic [4*PTR_W-1:0]   act_ptr,
    input logic [SHIFT_W-1:0]   act_shift
);
    a_r4_live_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_ptr));

    a_r5_shift_locked: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(act_shift));

    a_r6_start_while_run: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> run);

    a_r7_publish_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        publish |-> !run);

    a_r7_publish_single: assert property (@(posedge clk) disable iff (!rst_n)
        publish |=> !publish);

    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !publish);

    a_r10_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && op_done) |=> !publish);
endmodule

bind bignum_ctl_regs bignum_ctl_regs_chk #(.PTR_W(PTR_W), .SHIFT_W(SHIFT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_w), .stall(stall_w), .load(load_w),
    .op_done(op_done), .op_start(op_start), .publish(publish),
    .act_ptr(act_ptr), .act_shift(act_shift)
);

// File: tb/bignum_ctl_regs_test.sv
`timescale 1ns/1ps
module bignum_ctl_regs_test;
    localparam int BOOT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_idx = 3'd7;
    logic [31:0] rd_data;
    logic        op_done = 1'b0;
    logic        op_start, publish;
    logic [43:0] act_ptr;
    logic [17:0] act_len;
    logic [4:0]  act_shift;
    logic [11:0] act_ops;
    logic [2:0]  act_seq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bignum_ctl_regs #(.BOOT_CYCLES(BOOT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .op_done(op_done), .op_start(op_start), .publish(publish),
        .act_ptr(act_ptr), .act_len(act_len), .act_shift(act_shift),
        .act_ops(act_ops), .act_seq(act_seq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // state: 0 start-up, 1 idle, 2 running, 3 finished but held
    int          m_state, m_cnt;
    logic [10:0] m_ptr [4];
    logic [10:0] m_ptr_live [4];
    logic [8:0]  m_len [2];
    logic [8:0]  m_len_live [2];
    logic [4:0]  m_shift;
    logic [11:0] m_ops;
    logic [2:0]  m_seq;
    logic        m_stall, m_start, m_pub;

    function automatic logic [31:0] m_read(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1, 3'd2, 3'd3: return {21'b0, m_ptr[idx]};
            3'd4: return {23'b0, m_len[0]};
            3'd5: return {23'b0, m_len[1]};
            3'd6: return {27'b0, m_shift};
            default: return {7'b0, m_stall, 8'b0, (m_state != 1), m_seq, m_ops};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_stall = 0; m_start = 0; m_pub = 0;
            m_shift = 0; m_ops = 0; m_seq = 0;
            foreach (m_ptr[i]) begin m_ptr[i] = 0; m_ptr_live[i] = 0; end
            foreach (m_len[i]) begin m_len[i] = 0; m_len_live[i] = 0; end
        end else begin
            automatic bit old_run = (m_state != 1);
            automatic bit old_stall = m_stall;
            m_start = 0;
            m_pub = 0;
            if (m_state == 0) begin
                if (m_cnt == BOOT - 1) m_state = 1; else m_cnt++;
            end else if (m_state == 2 && op_done) begin
                if (old_stall) m_state = 3;
                else begin m_state = 1; m_pub = 1; end
            end else if (m_state == 3 && !old_stall) begin
                m_state = 1; m_pub = 1;
            end
            if (wr_en) begin
                if (wr_idx < 4) m_ptr[wr_idx] = wr_data[10:0];
                else if (wr_idx == 4) m_len[0] = wr_data[8:0];
                else if (wr_idx == 5) m_len[1] = wr_data[8:0];
                else if (wr_idx == 6) begin
                    if (!old_run) m_shift = wr_data[4:0];
                end else begin
                    if (!old_run) begin
                        m_ops = wr_data[11:0] & 12'hFFB;
                        m_seq = wr_data[14:12];
                        if (wr_data[15]) begin
                            m_state = 2;
                            m_start = 1;
                            foreach (m_ptr[i]) m_ptr_live[i] = m_ptr[i];
                            foreach (m_len[i]) m_len_live[i] = m_len[i];
                        end
                    end
                    m_stall = wr_data[24];
                end
            end
        end
    end

    // compare every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            chk("R6 op_start", 32'(op_start), 32'(m_start));
            chk("R7 publish", 32'(publish), 32'(m_pub));
            for (int i = 0; i < 4; i++)
                chk("R4 act_ptr", 32'(act_ptr[i*11 +: 11]), 32'(m_ptr_live[i]));
            for (int i = 0; i < 2; i++)
                chk("R4 act_len", 32'(act_len[i*9 +: 9]), 32'(m_len_live[i]));
            chk("R5 act_shift", 32'(act_shift), 32'(m_shift));
            chk("R6 act_ops", 32'(act_ops), 32'(m_ops));
            chk("R6 act_seq", 32'(act_seq), 32'(m_seq));
            if (rd_idx < 4) chk("R2 read", rd_data, m_read(rd_idx));
            else if (rd_idx < 6) chk("R3 read", rd_data, m_read(rd_idx));
            else if (rd_idx == 6) chk("R5 read", rd_data, m_read(rd_idx));
            else chk("R6 read", rd_data, m_read(rd_idx));
        end
    end

    // ---------------- stimulus helpers (start at a negedge) ----------------
    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        rd_idx = idx;
        #1;
        val = rd_data;
    endtask

    task automatic pulse_done();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] v;

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), v);
            chk("R1 reset zero", v, 32'h0);
        end
        rd(3'd7, v);
        chk("R1 reset function", v, 32'h0000_8000);
        rst_n = 1'b1;
        rd(3'd7, v);
        chk("R1 after release", v, 32'h0000_8000);

        // R9: start-up window locks function and shift
        wr(3'd7, 32'h0000_8001);
        wr(3'd6, 32'h0000_0009);
        rd(3'd7, v);
        chk("R9 run held in start-up", v, 32'h0000_8000);
        idle(BOOT);
        rd(3'd7, v);
        chk("R9 run cleared, write dropped", v, 32'h0);
        rd(3'd6, v);
        chk("R9 shift write dropped", v, 32'h0);

        // R2 / R3 / R5 field widths and reserved bits
        wr(3'd0, 32'hFFFF_FFFE);
        wr(3'd1, 32'h0000_0100);
        wr(3'd2, 32'h0000_0200);
        wr(3'd3, 32'h0000_0300);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0000_0010);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R2 pointer A masked", v, 32'h0000_07FE);
        rd(3'd3, v); chk("R2 pointer D", v, 32'h0000_0300);
        rd(3'd4, v); chk("R3 length A masked", v, 32'h0000_01FF);
        rd(3'd6, v); chk("R5 shift masked", v, 32'h0000_001F);
        chk("R4 live unchanged before start", 32'(act_ptr[10:0]), 32'h0);
        wr(3'd6, 32'h0000_0007);

        // R6: start, reserved bit 2 dropped
        wr(3'd7, 32'h0000_8015);
        rd(3'd7, v); chk("R6 function after start", v, 32'h0000_8011);
        chk("R4 live pointer A loaded", 32'(act_ptr[10:0]), 32'h7FE);
        chk("R4 live length A loaded", 32'(act_len[8:0]), 32'h1FF);

        // R4 / R5 / R6 writes during the running job
        wr(3'd0, 32'h0000_0040);
        wr(3'd6, 32'h0000_0003);
        wr(3'd7, 32'h0000_0800);
        rd(3'd0, v); chk("R4 pending pointer visible", v, 32'h0000_0040);
        chk("R4 live pointer kept", 32'(act_ptr[10:0]), 32'h7FE);
        rd(3'd6, v); chk("R5 shift locked", v, 32'h0000_0007);
        rd(3'd7, v); chk("R6 ops locked", v, 32'h0000_8011);

        // R7: completion
        pulse_done();
        chk("R7 publish pulse", 32'(publish), 32'h1);
        rd(3'd7, v); chk("R7 run cleared", v, 32'h0000_0011);
        idle(1);
        chk("R7 publish single cycle", 32'(publish), 32'h0);

        // R4: second job picks up pending pointer
        wr(3'd7, 32'h0000_8040);
        chk("R4 live pointer reloaded", 32'(act_ptr[10:0]), 32'h040);
        chk("R6 ops of second job", 32'(act_ops), 32'h040);
        idle(2);
        pulse_done();
        chk("R7 second publish", 32'(publish), 32'h1);

        // R8: stall-result hold-off
        wr(3'd7, 32'h0100_8020);
        rd(3'd7, v); chk("R8 start with stall", v, 32'h0100_8020);
        idle(2);
        pulse_done();
        chk("R8 no publish while stalled", 32'(publish), 32'h0);
        idle(3);
        rd(3'd7, v); chk("R8 run held", v, 32'h0100_8020);
        wr(3'd7, 32'h0000_0000);
        chk("R8 no publish on clearing edge", 32'(publish), 32'h0);
        rd(3'd7, v); chk("R8 run still set on clearing edge", v, 32'h0000_8020);
        idle(1);
        chk("R8 publish one edge later", 32'(publish), 32'h1);
        rd(3'd7, v); chk("R8 run cleared", v, 32'h0000_0020);

        // R10: stray done while idle
        idle(2);
        pulse_done();
        chk("R10 no publish when idle", 32'(publish), 32'h0);
        rd(3'd7, v); chk("R10 function unchanged", v, 32'h0000_0020);

        // sweep all indices against the model
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            @(negedge clk);
        end
        rd(3'd5, v); chk("R3 length B", v, 32'h0000_0010);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got=hung exp=complete");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule